// File: doc/BRIEF.md
# Prioritized interrupt status encoder

This block gathers the interrupt requests of one serial channel and shows the most urgent pending one as an 8-bit status byte. Seven request inputs are latched as pending flags: line-status error, receive data ready, receive time-out, transmit holding empty, modem status change, flow-stop (Xoff) or special-character match, and CTS/RTS change. A fixed priority picks one of them and encodes it into bits 5:1. Bit 0 and an active-high interrupt output show whether anything is pending at all.

The host reads the status byte and pulses a read strobe. That strobe clears only the source being reported at that moment, so lower sources come up on later reads. The flow-stop indication is different: once set, it stays set until a flow-resume (Xon) event arrives, and reads do not clear it. The two lowest sources take part only while the enhanced-features enable is high. Bits 7:6 mirror the FIFO-enabled flag.

Top module: `irq_prio_enc`

## Requirements
- R1: After reset the status byte reads 8'h01 with fifo_on low, and irq is low.
- R2: With one source pending alone, bits 5:0 read as follows: line status 000110, receive data ready 000100, receive time-out 001100, transmit holding empty 000010, modem status 000000, flow-stop/special character 010000, CTS/RTS change 100000.
- R3: The priority from highest to lowest is line status, receive time-out, receive data ready, transmit holding empty, modem status, flow-stop, CTS/RTS change. When time-out and data ready are both pending, the time-out code is shown.
- R4: irq is high exactly when an enabled source is pending, and bit 0 of the status is always the inverse of irq.
- R5: A read strobe clears only the source reported in that cycle. The next highest pending source is then reported from the following cycle on.
- R6: Bits 7:6 read 11 while fifo_on is 1 and 00 while it is 0.
- R7: While ext_en is 0, the flow-stop and CTS/RTS change sources appear neither in the status nor on irq.
- R8: Once the flow-stop indication is set, reads do not clear it. Only an ev_xon pulse clears it.
- R9: A request pulse that arrives in the same cycle as a read clearing that same source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Enhanced-features enable; admits the two lowest sources |
| fifo_on | input | 1 | FIFO-enabled flag shown in bits 7:6 |
| rd_stb | input | 1 | Status read strobe; clears the reported source |
| ev_line | input | 1 | Line-status error request |
| ev_rxdata | input | 1 | Receive data ready request |
| ev_rxto | input | 1 | Receive time-out request |
| ev_thre | input | 1 | Transmit holding empty request |
| ev_modem | input | 1 | Modem status change request |
| ev_xoff | input | 1 | Flow-stop or special character detected |
| ev_xon | input | 1 | Flow-resume received; clears flow-stop indication |
| ev_flow | input | 1 | CTS/RTS change request |
| stat | output | 8 | Coded status byte |
| irq | output | 1 | Interrupt output, high while a source is pending |

## Verification
The status output is combinational from the pending flags, so a wrong or stuck flag shows in the very next status sample after the edge that set it. It shows either as a wrong code or as a mismatch between bit 0 and irq. A clear that hits the wrong source only shows up when the read order is followed. For that reason the bench drains every combination of pending sources read by read and compares each code against the expected ordering. A flow-stop flag that reads clear by mistake shows up on the second read as a lower code.

// File: rtl/irq_prio_enc.sv
module irq_prio_enc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_en,
  input  logic       fifo_on,
  input  logic       rd_stb,
  input  logic       ev_line,
  input  logic       ev_rxdata,
  input  logic       ev_rxto,
  input  logic       ev_thre,
  input  logic       ev_modem,
  input  logic       ev_xoff,
  input  logic       ev_xon,
  input  logic       ev_flow,
  output logic [7:0] stat,
  output logic       irq
);
  logic p_ls, p_rd, p_to, p_th, p_ms, p_xf, p_fc;
  logic g_ls, g_rd, g_to, g_th, g_ms, g_fc;
  logic [4:0] code;

  wire xf_v = ext_en & p_xf;
  wire fc_v = ext_en & p_fc;

  assign g_ls = p_ls;
  assign g_to = p_to & ~p_ls;
  assign g_rd = p_rd & ~p_to & ~p_ls;
  assign g_th = p_th & ~p_rd & ~p_to & ~p_ls;
  assign g_ms = p_ms & ~p_th & ~p_rd & ~p_to & ~p_ls;
  assign g_fc = fc_v & ~xf_v & ~p_ms & ~p_th & ~p_rd & ~p_to & ~p_ls;

  always_comb begin
    if (p_ls)       code = 5'b00011;
    else if (p_to)  code = 5'b00110;
    else if (p_rd)  code = 5'b00010;
    else if (p_th)  code = 5'b00001;
    else if (p_ms)  code = 5'b00000;
    else if (xf_v)  code = 5'b01000;
    else if (fc_v)  code = 5'b10000;
    else            code = 5'b00000;
  end

  assign irq  = p_ls | p_to | p_rd | p_th | p_ms | xf_v | fc_v;
  assign stat = {{2{fifo_on}}, code, ~irq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ls <= 1'b0; p_rd <= 1'b0; p_to <= 1'b0; p_th <= 1'b0;
      p_ms <= 1'b0; p_xf <= 1'b0; p_fc <= 1'b0;
    end else begin
      p_ls <= ev_line   | (p_ls & ~(rd_stb & g_ls));
      p_to <= ev_rxto   | (p_to & ~(rd_stb & g_to));
      p_rd <= ev_rxdata | (p_rd & ~(rd_stb & g_rd));
      p_th <= ev_thre   | (p_th & ~(rd_stb & g_th));
      p_ms <= ev_modem  | (p_ms & ~(rd_stb & g_ms));
      p_xf <= ev_xoff   | (p_xf & ~ev_xon);
      p_fc <= ev_flow   | (p_fc & ~(rd_stb & g_fc));
    end
  end
endmodule

module irq_prio_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_en,
  input logic       fifo_on,
  input logic       rd_stb,
  input logic       ev_line,
  input logic       ev_rxdata,
  input logic       ev_rxto,
  input logic       ev_thre,
  input logic       ev_modem,
  input logic       ev_xon,
  input logic [7:0] stat,
  input logic       irq
);
  a_r4_bit0_vs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat[0] == !irq);

  a_r7_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> (stat[5:4] == 2'b00));

  a_r5_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && stat[5:1] == 5'b00011 && !ev_line) |=> (stat[5:1] != 5'b00011));

  a_r9_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ev_line |=> (!stat[0] && stat[5:1] == 5'b00011));

  a_r8_xoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && rd_stb && stat[5:1] == 5'b01000 && !ev_xon && !ev_line &&
     !ev_rxdata && !ev_rxto && !ev_thre && !ev_modem)
    |=> (!ext_en || stat[5:1] == 5'b01000));

  a_r6_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_on) |-> (stat[7:6] == 2'b11));
endmodule

bind irq_prio_enc irq_prio_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .fifo_on(fifo_on),
  .rd_stb(rd_stb), .ev_line(ev_line), .ev_rxdata(ev_rxdata),
  .ev_rxto(ev_rxto), .ev_thre(ev_thre), .ev_modem(ev_modem),
  .ev_xon(ev_xon), .stat(stat), .irq(irq)
);

// File: tb/irq_prio_enc_bench.sv
module irq_prio_enc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_en = 1'b0, fifo_on = 1'b0, rd_stb = 1'b0;
  logic ev_line = 0, ev_rxdata = 0, ev_rxto = 0, ev_thre = 0;
  logic ev_modem = 0, ev_xoff = 0, ev_xon = 0, ev_flow = 0;
  logic [7:0] stat;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_prio_enc u_irq_prio_enc (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .fifo_on(fifo_on),
    .rd_stb(rd_stb), .ev_line(ev_line), .ev_rxdata(ev_rxdata),
    .ev_rxto(ev_rxto), .ev_thre(ev_thre), .ev_modem(ev_modem),
    .ev_xoff(ev_xoff), .ev_xon(ev_xon), .ev_flow(ev_flow),
    .stat(stat), .irq(irq)
  );

  // source index order = priority: 0 line, 1 rxto, 2 rxdata, 3 thre, 4 modem, 5 xoff, 6 flow
  function automatic logic [4:0] code_of(int i);
    case (i)
      0: return 5'b00011;
      1: return 5'b00110;
      2: return 5'b00010;
      3: return 5'b00001;
      5: return 5'b01000;
      6: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // bit 7 = xon, bits 6:0 follow the source index order
  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    ev_line = m[0]; ev_rxto = m[1]; ev_rxdata = m[2]; ev_thre = m[3];
    ev_modem = m[4]; ev_xoff = m[5]; ev_flow = m[6]; ev_xon = m[7];
    @(negedge clk);
    {ev_line, ev_rxto, ev_rxdata, ev_thre, ev_modem, ev_xoff, ev_flow, ev_xon} = '0;
    #1;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    #1;
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    logic [6:0] model;
    int top;
    do_reset();
    #1;
    chk(stat == 8'h01 && !irq, "R1 reset", stat, 8'h01);

    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 128; m++) begin
        ext_en  = e[0];
        fifo_on = m[0] ^ e[0];
        do_reset();
        pulse({1'b0, m[6:0]});
        model = m[6:0];
        if (e == 0) model[6:5] = 2'b00;
        for (int step = 0; step < 10; step++) begin
          top = -1;
          for (int i = 6; i >= 0; i--) if (model[i]) top = i;
          if (top < 0) begin
            exp = {{2{fifo_on}}, 5'b00000, 1'b1};
            chk(stat == exp && !irq, "R4 idle after drain", stat, exp);
            break;
          end
          exp = {{2{fifo_on}}, code_of(top), 1'b0};
          if ($countones(model) == 1)
            chk(stat == exp, "R2 single source code", stat, exp);
          else
            chk(stat == exp, "R3 priority pick", stat, exp);
          chk(irq == 1'b1, "R4 irq pending", {7'b0, irq}, 8'h01);
          chk(stat[7:6] == {2{fifo_on}}, "R6 fifo bits", stat, exp);
          if (e == 0)
            chk(stat[5:4] == 2'b00, "R7 masked sources", stat, exp);
          if (top == 5) begin
            do_read();
            chk(stat == exp, "R8 xoff survives read", stat, exp);
            pulse(8'h80);
            model[5] = 1'b0;
          end else begin
            do_read();
            model[top] = 1'b0;
            top = -1;
            for (int i = 6; i >= 0; i--) if (model[i]) top = i;
            exp = (top < 0) ? {{2{fifo_on}}, 5'b0, 1'b1} : {{2{fifo_on}}, code_of(top), 1'b0};
            chk(stat == exp, "R5 next after read", stat, exp);
          end
        end
      end
    end

    // R9: a new line request in the same cycle as the read that clears it
    ext_en = 1'b1; fifo_on = 1'b0;
    do_reset();
    pulse(8'h01);
    @(negedge clk);
    rd_stb = 1'b1; ev_line = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; ev_line = 1'b0;
    #1;
    chk(stat == 8'h06 && irq, "R9 set beats clear", stat, 8'h06);

    // R7: flow change masked while ext_en low, irq stays low
    ext_en = 1'b0;
    do_reset();
    pulse(8'h60);
    chk(!irq && stat == 8'h01, "R7 masked no irq", stat, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule